// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block generates instruction fetch addresses for a small 8-bit controller core. It keeps a 13-bit program counter, so the code space it can name is 8K words. The program memory behind it holds only 2K words, so the fetch address carries the low 11 bits of the counter and the two upper bits are dropped. A branch into the upper span therefore lands on the matching word in the implemented 2K.

Each cycle the decode stage asserts at most a few control strobes: advance, jump, call, return, or interrupt taken. The block applies them in a fixed priority. Calls and interrupts save a return address in a private 8-level stack. Returns restore the saved address. The stack is circular and reports no errors. Software has no path to read or write it.

Top module: `pc_retstack`

## Requirements
- R1: While `rst_n` is low the counter is 0x0000. After release it stays there until a strobe changes it.
- R2: `fetch_addr` always equals the low 11 bits of `pc`. Bits 12:11 of `pc` have no effect on it.
- R3: With `inc_en` as the only strobe, `pc` becomes `pc+1` one cycle later. It wraps from 0x1FFF to 0x0000.
- R4: With no strobe asserted, `pc` keeps its value.
- R5: `jump_req` loads `pc` with `target` and leaves the stack untouched.
- R6: `call_req` pushes `pc+1` and loads `pc` with `target`.
- R7: `ret_req` pops the most recently pushed address into `pc`.
- R8: `irq_take` loads 0x0004 and pushes the current, not incremented, `pc`.
- R9: Priority runs from highest to lowest as reset, `irq_take`, `call_req`, `jump_req`, `ret_req`, `inc_en`. A strobe that loses does nothing, including to the stack.
- R10: The stack holds 8 entries in a ring. A ninth push overwrites the oldest entry. A pop past empty wraps around and returns the entry in that ring slot, with no flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_take | input | 1 | Interrupt accepted this cycle |
| inc_en | input | 1 | Advance to the next word |
| jump_req | input | 1 | Load `target` |
| call_req | input | 1 | Push return address and load `target` |
| ret_req | input | 1 | Pop return address into the counter |
| target | input | 13 | Destination for jump and call |
| fetch_addr | output | 11 | Address driven to program memory |
| pc | output | 13 | Full program counter |

## Verification
The in-line assertions check the following on every cycle: the interrupt vector load, the target load for calls and jumps, the increment step, and holding when idle. They also check that a lone return restores the address held in the top stack slot. Only the bench's scenarios can show the stack's content order across a run. These scenarios cover nesting to full depth, the ninth push replacing the oldest entry, and the pop order after wraparound. The bench also sweeps `fetch_addr` folding across the whole 13-bit span.

// File: rtl/pc_retstack.sv
module pc_retstack #(
  parameter int unsigned PC_W    = 13,
  parameter int unsigned MEM_AW  = 11,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned RST_VEC = 0,
  parameter int unsigned IRQ_VEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              inc_en,
  input  logic              jump_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [PC_W-1:0]   target,
  output logic [MEM_AW-1:0] fetch_addr,
  output logic [PC_W-1:0]   pc
);
  localparam int unsigned SP_W = $clog2(DEPTH);

  logic [PC_W-1:0] stk [DEPTH];
  logic [SP_W-1:0] sp;

  wire [PC_W-1:0] pc_nxt  = pc + 1'b1;
  wire [SP_W-1:0] sp_dn   = sp - 1'b1;
  wire            do_push = irq_take | call_req;
  wire            do_pop  = ret_req & ~irq_take & ~call_req & ~jump_req;
  wire [PC_W-1:0] push_v  = irq_take ? pc : pc_nxt;

  assign fetch_addr = pc[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= PC_W'(RST_VEC);
    else if (irq_take) pc <= PC_W'(IRQ_VEC);
    else if (call_req) pc <= target;
    else if (jump_req) pc <= target;
    else if (ret_req)  pc <= stk[sp_dn];
    else if (inc_en)   pc <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= '0;
    else if (do_push) sp <= sp + 1'b1;
    else if (do_pop)  sp <= sp_dn;
  end

  always_ff @(posedge clk) begin
    if (rst_n && do_push) stk[sp] <= push_v;
  end

  // R8
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc == PC_W'(IRQ_VEC));

  // R5
  target_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_take && (call_req || jump_req)) |=> pc == $past(target));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !irq_take && !call_req && !jump_req && !ret_req)
      |=> pc == $past(pc) + 1'b1);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !irq_take && !call_req && !jump_req && !ret_req) |=> $stable(pc));

  // R7
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> pc == $past(stk[sp_dn]));
endmodule

// File: tb/pc_retstack_bench.sv
module pc_retstack_bench;
  logic clk = 0, rst_n = 0;
  logic irq_take = 0, inc_en = 0, jump_req = 0, call_req = 0, ret_req = 0;
  logic [12:0] target = 0;
  logic [10:0] fetch_addr;
  logic [12:0] pc;
  int tests = 0, fails = 0;
  int cyc = 0;
  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int m_sp;

  pc_retstack u_pc_retstack (.clk, .rst_n, .irq_take, .inc_en, .jump_req,
    .call_req, .ret_req, .target, .fetch_addr, .pc);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag);
    tests++;
    if (pc !== m_pc || fetch_addr !== m_pc[10:0]) begin
      fails++;
      $display("FAIL %s: pc=%h fetch=%h expected pc=%h fetch=%h",
               tag, pc, fetch_addr, m_pc, m_pc[10:0]);
    end
  endtask

  task automatic op(input logic i, c, j, r, n, input logic [12:0] t, input string tag);
    irq_take = i; call_req = c; jump_req = j; ret_req = r; inc_en = n; target = t;
    @(negedge clk);
    if (i) begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 13'h0004; end
    else if (c) begin m_stk[m_sp] = m_pc + 1; m_sp = (m_sp + 1) % 8; m_pc = t; end
    else if (j) m_pc = t;
    else if (r) begin m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; end
    else if (n) m_pc = m_pc + 1;
    irq_take = 0; call_req = 0; jump_req = 0; ret_req = 0; inc_en = 0;
    check(tag);
  endtask

  initial begin
    m_pc = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");
    op(0,0,0,0,0,0,"R4 idle");
    for (int t = 0; t < 8192; t += 37) op(0,0,1,0,0,13'(t),"R2/R5 jump fold");
    op(0,0,1,0,0,13'h1FFD,"R5 jump high");
    for (int k = 0; k < 4; k++) op(0,0,0,0,1,0,"R3 step wrap");
    op(0,0,0,0,0,0,"R4 idle");
    for (int d = 0; d < 8; d++) op(0,1,0,0,0,13'(100 * d + 7),"R6 nested call");
    for (int d = 0; d < 8; d++) op(0,0,0,1,0,0,"R7 nested return");
    for (int d = 0; d < 9; d++) op(0,1,0,0,1,13'(16'h0800 + 3 * d),"R10 overflow push");
    for (int d = 0; d < 10; d++) op(0,0,0,1,0,0,"R10 wrap pop");
    op(0,0,1,0,0,13'h0123,"R5 jump");
    op(1,0,0,0,0,0,"R8 irq vector");
    op(0,0,0,0,1,0,"R3 step in isr");
    op(0,0,0,1,0,0,"R8 irq return");
    op(1,1,1,1,1,13'h0555,"R9 irq wins");
    op(0,1,1,1,1,13'h0666,"R9 call wins");
    op(0,0,1,1,1,13'h0777,"R9 jump wins");
    op(0,0,0,1,1,0,"R9 return wins");
    op(0,0,0,1,0,0,"R9 return");
    rst_n = 0; #1;
    m_pc = 0; m_sp = 0;
    check("R1 async reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 held after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    tests++; fails++;
    $display("FAIL watchdog: cycles=%0d expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule